// File: doc/BRIEF.md
# Queue Head Transfer Descriptor Advance Engine

This block walks one endpoint's queue kept in shared memory. Each non-isochronous endpoint owns exactly one queue, anchored by a queue head that holds an overlay: a working copy of the descriptor now executing. The overlay's link word names the next descriptor to try. When the scheduler visits the queue, the engine fetches the queue head, follows that link, and reads the descriptor it points to. If the descriptor is active, the engine copies it into the overlay. The overlay's link then comes from the copied descriptor.

With the overlay loaded, the engine hands the buffer pointer and byte count to a transaction executor and waits. The executor may run a single transaction (setup or status) or many (a data stage). When it reports completion, the engine writes the retired status word back to the descriptor and to the overlay, then follows the inherited link. It keeps going until the link is terminated, points at an inactive descriptor, or a halt is seen. Because work runs from the overlay, software may link new descriptors onto the tail at any time with no handshake. The next visit picks them up.

All memory traffic uses a word-wide request port with a request/acknowledge handshake. Multi-word reads and writes go out as back-to-back beats at ascending addresses.

Top module: `qh_advance_engine`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `mem_req_o`, `exec_go_o` and `done_o` are low.
- R2: A visit pulse while idle starts a burst of three reads at the queue head address plus 0, 4 and 8. These words are the link word, the current-descriptor pointer and the status token.
- R3: If the link word has bit 0 set, the visit ends with `done_code_o` = 1. No memory write occurs and the executor is not started.
- R4: A descriptor's words are link (offset 0), status token (offset 4) and buffer pointer (offset 8). The token holds active at bit 7, halted at bit 6, and the byte count at bits 30:16. If the active bit is clear, the visit ends with code 2, with no memory write and no executor start.
- R5: An active descriptor is copied into the queue head as a four-beat write burst before the executor starts. The burst writes, at offsets 0, 4, 8 and 12: its link, its own address, its token and its buffer pointer.
- R6: `exec_go_o` stays high, with no memory request, until `exec_done_i`. While it is high, `exec_buf_o` and `exec_len_o` carry the descriptor's buffer pointer and byte count.
- R7: On completion, the token is rewritten with active cleared, halted set to `exec_halt_i`, and the byte count replaced by `exec_remain_i`. All other token bits are kept. The new token is written first to the descriptor (offset 4) and then to the queue head (offset 8).
- R8: A descriptor that retires without halt is followed by its inherited link within the same visit, so chained descriptors all retire in one visit.
- R9: A halted bit in the queue head token at visit start ends the visit with code 3 and no writes. An executor halt ends the visit with code 3 after write-back.
- R10: Pointer bits 4:0 are ignored when forming addresses; only bit 0 of a link has meaning (terminate). Every memory address is word aligned.
- R11: `done_o` is a one-cycle pulse followed by idle. A later visit re-reads memory and picks up descriptors activated or appended since.
- R12: A memory request holds its address, direction and write data steady until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| visit_i | input | 1 | Schedule visit pulse, taken when idle |
| qh_addr_i | input | 32 | Queue head byte address |
| busy_o | output | 1 | Visit in progress |
| done_o | output | 1 | One-cycle end-of-visit pulse |
| done_code_o | output | 2 | 1 terminate, 2 inactive, 3 halted |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | 32 | Beat byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Beat accepted; read data valid |
| mem_rdata_i | input | 32 | Read data |
| exec_go_o | output | 1 | Executor start, held until done |
| exec_buf_o | output | 32 | Descriptor buffer pointer |
| exec_len_o | output | 15 | Descriptor byte count |
| exec_done_i | input | 1 | Executor finished |
| exec_remain_i | input | 15 | Bytes left untransferred |
| exec_halt_i | input | 1 | Executor stopped with error |

## Verification
The bench aims at the stop conditions: a terminate bit hidden among other flag bits, a chain that ends on an inactive descriptor, a halt raised by the executor mid-chain, and a halt already present in the overlay. A design that confused them would return the wrong code, start the executor on stale data, or write memory it should leave alone. The bench also flips an inactive tail to active and revisits, catching an engine that caches state between visits. It watches the write-back order, because a status written to the overlay before the descriptor leaves a window in which software sees a retired overlay over a still-active descriptor. Random chains with flag bits in pointer low bits expose any address path that forgets to mask them.

// File: rtl/qh_pkg.sv
package qh_pkg;
  localparam int ADDR_W      = 32;
  localparam int ALIGN_BITS  = 5;
  localparam int TOK_ACTIVE  = 7;
  localparam int TOK_HALT    = 6;
  localparam int LEN_LSB     = 16;
  localparam int LEN_W       = 15;
  localparam int QH_RD_BEATS = 3;
  localparam int TD_RD_BEATS = 3;
  localparam int OV_WR_BEATS = 4;
  localparam int BEAT_W      = $clog2(OV_WR_BEATS);
  localparam int QH_TOK_OFS  = 8;
  localparam int TD_TOK_OFS  = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_QH_RD, S_CHK_QH, S_TD_RD, S_CHK_TD,
    S_OV_WR, S_EXEC, S_WB_TD, S_WB_QH, S_END
  } state_e;

  typedef enum logic [1:0] {
    END_NONE = 2'd0, END_TERM = 2'd1, END_INACT = 2'd2, END_HALT = 2'd3
  } end_e;

  typedef struct packed {
    logic [ADDR_W-1:0] nxt;
    logic [ADDR_W-1:0] cur;
    logic [31:0]       tok;
    logic [ADDR_W-1:0] bufp;
  } ovl_t;
endpackage

// File: rtl/qh_beat_ctr.sv
module qh_beat_ctr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         adv_i,
  output logic [W-1:0] idx_o
);
  logic [W-1:0] idx_q, idx_d;
  logic         idx_en;

  always_comb begin
    idx_en = clr_i | adv_i;
    idx_d  = clr_i ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/qh_token_codec.sv
module qh_token_codec
  import qh_pkg::*;
(
  input  logic [31:0]      tok_i,
  input  logic [LEN_W-1:0] remain_i,
  input  logic             halt_i,
  output logic             active_o,
  output logic             halted_o,
  output logic [LEN_W-1:0] len_o,
  output logic [31:0]      retired_o
);
  always_comb begin
    active_o  = tok_i[TOK_ACTIVE];
    halted_o  = tok_i[TOK_HALT];
    len_o     = tok_i[LEN_LSB +: LEN_W];
    retired_o = tok_i;
    retired_o[TOK_ACTIVE]         = 1'b0;
    retired_o[TOK_HALT]           = halt_i;
    retired_o[LEN_LSB +: LEN_W]   = remain_i;
  end
endmodule

// File: rtl/qh_advance_engine.sv
module qh_advance_engine
  import qh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              visit_i,
  input  logic [ADDR_W-1:0] qh_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        done_code_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              exec_go_o,
  output logic [ADDR_W-1:0] exec_buf_o,
  output logic [LEN_W-1:0]  exec_len_o,
  input  logic              exec_done_i,
  input  logic [LEN_W-1:0]  exec_remain_i,
  input  logic              exec_halt_i
);
  localparam logic [BEAT_W-1:0] QH_LAST = BEAT_W'(QH_RD_BEATS - 1);
  localparam logic [BEAT_W-1:0] TD_LAST = BEAT_W'(TD_RD_BEATS - 1);
  localparam logic [BEAT_W-1:0] OV_LAST = BEAT_W'(OV_WR_BEATS - 1);

  state_e            state_q, state_d;
  end_e              code_q, code_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] qh_q;
  ovl_t              ov_q, ov_d;
  logic              ld_qh, ov_en, code_en;
  logic              beat_clr, beat_adv;
  logic [BEAT_W-1:0] beat_idx;
  logic              tok_active, tok_halted;
  logic [LEN_W-1:0]  tok_len;
  logic [31:0]       tok_retired;
  logic              unused_lo;

  assign unused_lo = ^qh_addr_i[ALIGN_BITS-1:0];

  qh_beat_ctr #(.W(BEAT_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .clr_i(beat_clr), .adv_i(beat_adv), .idx_o(beat_idx)
  );

  qh_token_codec u_tok (
    .tok_i(ov_q.tok), .remain_i(exec_remain_i), .halt_i(exec_halt_i),
    .active_o(tok_active), .halted_o(tok_halted), .len_o(tok_len),
    .retired_o(tok_retired)
  );

  // Sequencer next-state
  always_comb begin
    state_d  = state_q;
    code_d   = code_q;
    base_d   = base_q;
    ov_d     = ov_q;
    ld_qh    = 1'b0;
    beat_clr = 1'b0;
    beat_adv = 1'b0;
    unique case (state_q)
      S_IDLE: if (visit_i) begin
        base_d   = {qh_addr_i[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        ld_qh    = 1'b1;
        beat_clr = 1'b1;
        state_d  = S_QH_RD;
      end
      S_QH_RD: if (mem_ack_i) begin
        case (beat_idx)
          2'd0:    ov_d.nxt = mem_rdata_i;
          2'd1:    ov_d.cur = mem_rdata_i;
          default: ov_d.tok = mem_rdata_i;
        endcase
        if (beat_idx == QH_LAST) begin beat_clr = 1'b1; state_d = S_CHK_QH; end
        else beat_adv = 1'b1;
      end
      S_CHK_QH: begin
        if (tok_halted) begin
          code_d = END_HALT; state_d = S_END;
        end else if (ov_q.nxt[0]) begin
          code_d = END_TERM; state_d = S_END;
        end else begin
          base_d   = {ov_q.nxt[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
          beat_clr = 1'b1;
          state_d  = S_TD_RD;
        end
      end
      S_TD_RD: if (mem_ack_i) begin
        case (beat_idx)
          2'd0:    ov_d.nxt  = mem_rdata_i;
          2'd1:    ov_d.tok  = mem_rdata_i;
          default: ov_d.bufp = mem_rdata_i;
        endcase
        if (beat_idx == TD_LAST) begin beat_clr = 1'b1; state_d = S_CHK_TD; end
        else beat_adv = 1'b1;
      end
      S_CHK_TD: begin
        if (!tok_active) begin
          code_d = END_INACT; state_d = S_END;
        end else begin
          ov_d.cur = base_q;
          base_d   = qh_q;
          beat_clr = 1'b1;
          state_d  = S_OV_WR;
        end
      end
      S_OV_WR: if (mem_ack_i) begin
        if (beat_idx == OV_LAST) begin beat_clr = 1'b1; state_d = S_EXEC; end
        else beat_adv = 1'b1;
      end
      S_EXEC: if (exec_done_i) begin
        ov_d.tok = tok_retired;
        state_d  = S_WB_TD;
      end
      S_WB_TD: if (mem_ack_i) state_d = S_WB_QH;
      S_WB_QH: if (mem_ack_i) begin
        if (tok_halted) begin code_d = END_HALT; state_d = S_END; end
        else state_d = S_CHK_QH;
      end
      S_END:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    ov_en   = (ov_d != ov_q);
    code_en = (code_d != code_q);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      code_q  <= END_NONE;
      base_q  <= '0;
      qh_q    <= '0;
      ov_q    <= '0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      if (code_en) code_q <= code_d;
      if (ld_qh)   qh_q   <= base_d;
      if (ov_en)   ov_q   <= ov_d;
    end
  end

  // Outputs
  always_comb begin
    busy_o      = (state_q != S_IDLE);
    done_o      = (state_q == S_END);
    done_code_o = code_q;
    mem_req_o   = (state_q == S_QH_RD) || (state_q == S_TD_RD) || (state_q == S_OV_WR) ||
                  (state_q == S_WB_TD) || (state_q == S_WB_QH);
    mem_we_o    = (state_q == S_OV_WR) || (state_q == S_WB_TD) || (state_q == S_WB_QH);
    mem_addr_o  = base_q + {{(ADDR_W-BEAT_W-2){1'b0}}, beat_idx, 2'b00};
    mem_wdata_o = '0;
    unique case (state_q)
      S_WB_TD: begin mem_addr_o = ov_q.cur + TD_TOK_OFS; mem_wdata_o = ov_q.tok; end
      S_WB_QH: begin mem_addr_o = qh_q + QH_TOK_OFS;     mem_wdata_o = ov_q.tok; end
      S_OV_WR: begin
        case (beat_idx)
          2'd0:    mem_wdata_o = ov_q.nxt;
          2'd1:    mem_wdata_o = ov_q.cur;
          2'd2:    mem_wdata_o = ov_q.tok;
          default: mem_wdata_o = ov_q.bufp;
        endcase
      end
      default: ;
    endcase
    exec_go_o  = (state_q == S_EXEC);
    exec_buf_o = ov_q.bufp;
    exec_len_o = tok_len;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o && !exec_go_o && !done_o); // R1
  AST_TERM_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CHK_QH && !tok_halted && ov_q.nxt[0]) |=> done_o && done_code_o == END_TERM); // R3
  AST_GO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go_o && !exec_done_i |=> exec_go_o); // R6
  AST_GO_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go_o |-> !mem_req_o); // R6
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o); // R11
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
    $stable(mem_we_o) && $stable(mem_wdata_o)); // R12
endmodule

// File: tb/qh_advance_engine_bench.sv
`timescale 1ns/1ps
module qh_advance_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        visit_i = 1'b0;
  logic [31:0] qh_addr_i = '0;
  logic        busy_o, done_o;
  logic [1:0]  done_code_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        exec_go_o;
  logic [31:0] exec_buf_o;
  logic [14:0] exec_len_o;
  logic        exec_done_i = 1'b0;
  logic [14:0] exec_remain_i = '0;
  logic        exec_halt_i = 1'b0;

  always #2 clk = ~clk;

  qh_advance_engine u_qh_advance_engine (.*);

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] mem [0:255];
  logic [31:0] exp_mem [0:255];
  logic [14:0] rem_plan [0:31];
  logic        halt_plan [0:31];
  int          acc_cnt, wr_cnt, exp_wr, wb_stage;
  logic [31:0] acc_addr [0:2];
  logic        acc_we [0:2];
  logic [31:0] wb_td;
  logic [1:0]  exp_code;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int widx(input logic [31:0] a);
    return int'(a[9:2]);
  endfunction

  // Memory and executor models, driven away from the active edge
  always @(negedge clk) begin
    mem_ack_i   <= 1'b0;
    exec_done_i <= 1'b0;
    if (mem_req_o && ($urandom % 4) != 0) begin
      mem_ack_i <= 1'b1;
      if (acc_cnt < 3) begin acc_addr[acc_cnt] = mem_addr_o; acc_we[acc_cnt] = mem_we_o; end
      acc_cnt++;
      if (mem_we_o) begin
        mem[widx(mem_addr_o)] = mem_wdata_o;
        wr_cnt++;
        if (wb_stage == 1) begin
          chk(mem_addr_o == wb_td + 4, "R7 descriptor written first", mem_addr_o, wb_td + 4);
          wb_stage = 2;
        end else if (wb_stage == 2) begin
          chk(mem_addr_o == qh_addr_i + 8, "R7 queue head token second", mem_addr_o, qh_addr_i + 8);
          wb_stage = 0;
        end
      end else
        mem_rdata_i <= mem[widx(mem_addr_o)];
    end
    if (exec_go_o && !exec_done_i && ($urandom % 3) == 0) begin
      automatic int s = int'(exec_buf_o[16:12]);
      chk(exec_len_o == mem[s*8+1][30:16], "R6 exec length", {17'h0, exec_len_o}, {17'h0, mem[s*8+1][30:16]});
      chk(exec_buf_o == mem[s*8+2], "R6 exec buffer", exec_buf_o, mem[s*8+2]);
      exec_done_i   <= 1'b1;
      exec_remain_i <= rem_plan[s];
      exec_halt_i   <= halt_plan[s];
      wb_td    = {22'h0, s[4:0], 5'h0};
      wb_stage = 1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] mk_tok(input bit act, input bit halt, input logic [14:0] len);
    logic [31:0] t;
    t = $urandom;
    t[31] = 1'b0; t[30:16] = len; t[7] = act; t[6] = halt;
    return t;
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 32; i++) begin rem_plan[i] = 15'($urandom); halt_plan[i] = 1'b0; end
  endtask

  task automatic set_td(input int s, input logic [31:0] nxt, input logic [31:0] tok);
    mem[s*8]   = nxt;
    mem[s*8+1] = tok;
    mem[s*8+2] = {15'h0, 5'(s), 12'($urandom)};
  endtask

  // Expected-result walk computed from the requirements
  task automatic model_visit();
    logic [31:0] nxt, td, t, nt;
    int s;
    exp_wr = 0;
    for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
    if (exp_mem[2][6]) begin exp_code = 2'd3; return; end
    for (int k = 0; k < 40; k++) begin
      nxt = exp_mem[0];
      if (nxt[0]) begin exp_code = 2'd1; return; end
      td = {nxt[31:5], 5'h0};
      t  = exp_mem[widx(td) + 1];
      if (!t[7]) begin exp_code = 2'd2; return; end
      s = int'(td[9:5]);
      exp_mem[0] = exp_mem[widx(td)];
      exp_mem[1] = td;
      exp_mem[3] = exp_mem[widx(td) + 2];
      nt = t; nt[7] = 1'b0; nt[6] = halt_plan[s]; nt[30:16] = rem_plan[s];
      exp_mem[widx(td) + 1] = nt;
      exp_mem[2] = nt;
      exp_wr += 6;
      if (halt_plan[s]) begin exp_code = 2'd3; return; end
    end
  endtask

  task automatic run_visit(input string tag);
    int bad = 0;
    model_visit();
    @(negedge clk);
    acc_cnt = 0; wr_cnt = 0; wb_stage = 0;
    qh_addr_i = 32'h0;
    visit_i = 1'b1;
    @(negedge clk);
    visit_i = 1'b0;
    while (!done_o) @(negedge clk);
    chk(done_code_o == exp_code, {tag, " R3 R4 R9 end code"}, {30'h0, done_code_o}, {30'h0, exp_code});
    chk(acc_addr[0] == 0 && acc_addr[1] == 4 && acc_addr[2] == 8 && !acc_we[0] && !acc_we[1] && !acc_we[2],
        {tag, " R2 queue head burst"}, acc_addr[2], 32'h8);
    chk(wr_cnt == exp_wr, {tag, " R3 R4 R5 write count"}, wr_cnt, exp_wr);
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(bad == 0, {tag, " R5 R7 R8 memory image"}, bad, 0);
    @(negedge clk);
    chk(!busy_o && !done_o, {tag, " R11 back to idle"}, {31'h0, busy_o}, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    acc_cnt = 0; wr_cnt = 0; wb_stage = 0;
    clear_mem();
    repeat (3) @(negedge clk);
    chk(!busy_o && !mem_req_o && !exec_go_o && !done_o, "R1 reset quiet", {31'h0, mem_req_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !mem_req_o && !exec_go_o, "R1 after reset", {31'h0, busy_o}, 0);

    // R3: terminate with other flag bits present (R10)
    clear_mem();
    mem[0] = 32'h0000_004B; mem[2] = mk_tok(0, 0, 15'd5);
    run_visit("term");

    // R4: inactive descriptor
    clear_mem();
    mem[0] = 32'h0000_0020; mem[2] = mk_tok(0, 0, 0);
    set_td(1, 32'h1, mk_tok(0, 0, 15'd64));
    run_visit("inactive");

    // R8 R10: chain with flag bits in links, ends on inactive; then R11 activate tail
    clear_mem();
    mem[0] = 32'h0000_0020 | 32'h1E;
    set_td(1, 32'h0000_0040 | 32'h0C, mk_tok(1, 0, 15'd8));
    set_td(2, 32'h0000_0060, mk_tok(1, 0, 15'd512));
    set_td(3, 32'h1, mk_tok(0, 0, 15'd13));
    run_visit("chain");
    mem[3*8+1][7] = 1'b1;
    run_visit("R11 appended");

    // R9: executor halt mid-chain, then halted overlay, then cleared
    clear_mem();
    mem[0] = 32'h0000_0020;
    set_td(1, 32'h0000_0040, mk_tok(1, 0, 15'd100));
    set_td(2, 32'h0000_0060, mk_tok(1, 0, 15'd200));
    set_td(3, 32'h1, mk_tok(1, 0, 15'd300));
    halt_plan[2] = 1'b1;
    run_visit("R9 exec halt");
    run_visit("R9 halted overlay");
    mem[2][6] = 1'b0;
    run_visit("R9 cleared");

    // Random chains
    for (int it = 0; it < 30; it++) begin
      automatic int len = $urandom % 6;
      automatic int st  = $urandom % 31;
      int sl [0:6];
      clear_mem();
      for (int i = 0; i <= len; i++) sl[i] = 1 + ((st + i * 7) % 31);
      for (int i = 0; i < 32; i++) halt_plan[i] = (($urandom % 7) == 0);
      mem[2] = mk_tok(0, (($urandom % 10) == 0), 15'($urandom));
      mem[0] = (len == 0) ? (32'h1 | 32'($urandom % 32)) : (32'(sl[0] * 32) | 32'(($urandom % 16) << 1));
      for (int i = 0; i < len; i++) begin
        automatic logic [31:0] nx;
        if (i == len - 1) nx = ($urandom % 2) ? (32'h1 | 32'(sl[i] * 32)) : 32'(sl[len] * 32);
        else nx = 32'(sl[i+1] * 32) | 32'(($urandom % 16) << 1);
        set_td(sl[i], nx, mk_tok(1, 0, 15'($urandom)));
      end
      set_td(sl[len], 32'h1, mk_tok(0, 0, 15'($urandom)));
      run_visit("random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule